// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the software-visible face of a byte-oriented asynchronous serial port. A 32-bit single-cycle bus reaches ten word registers. Through them software loads a transmit queue, drains a receive queue, and reads line and error status. The same registers hold the framing, modem-control and baud-divisor settings, and software arms one interrupt line through them. The serial shifters sit outside the block. The transmit side takes bytes from the head of the transmit queue through a pop strobe. The receive side pushes bytes, each with its error strobes, into the receive queue.

The interrupt register is split into two halves. The upper nibble holds enables that software writes. The lower bits hold latched status, which a read of that register clears. A write of any value to the receive-count register discards everything waiting in the receive queue.

Top module: `uart_regfile`

## Requirements
- R1: After reset, every register reads zero except line status, which reads 0x41 (room to transmit, transmit queue empty), and the interrupt output is low.
- R2: A write to offset 0x00 appends bits [7:0] to the transmit queue, and `tx_data`/`tx_valid` present the oldest byte until `tx_pop`. A write made while the queue holds DEPTH bytes is dropped.
- R3: A read of offset 0x00 returns the oldest received byte and removes it. When the receive queue is empty, the read returns 0 and has no other effect.
- R4: Line status (0x04) bit 0 is 1 while the transmit queue is not full, bit 1 is 1 while the receive queue is not empty, and bit 6 is 1 while the transmit queue is empty.
- R5: Line status bit 2 (parity), bit 4 (framing) and bit 5 (break) are set when `rx_push` arrives with the matching strobe. Bit 3 (overrun) is set when `rx_push` arrives while the receive queue is full, and that byte is lost. These four bits hold until line status is read. An event in the same cycle as the read survives the read.
- R6: Interrupt register (0x1C) bit 1 latches while the receive queue is non-empty, and bit 0 latches while the transmit queue is not full. A read of the register returns the status and then clears it. A condition that still holds latches again one cycle later.
- R7: A write to 0x1C loads only the enables in bits [7:4] (bit 5 enables receive, bit 4 enables transmit) and leaves the status bits unchanged.
- R8: `irq` is high exactly when (status bit 1 and enable bit 5) or (status bit 0 and enable bit 4).
- R9: Offset 0x20 reads the transmit queue count and offset 0x24 reads the receive queue count. A write to 0x24 empties the receive queue and discards a byte pushed in the same cycle. A write to 0x20 has no effect.
- R10: Line control (0x0C, 8 bits) drives `line_ctrl`, and its bit 5 drives `tx_break`. Modem control (0x10, 5 bits) drives `modem_ctrl`. Divisor low (0x14, 16 bits) and divisor high (0x18, 8 bits) form `baud_div` = {high, low}. Modem status (0x08) reads `modem_in`.
- R11: Reads of word offsets 0x28 to 0x3C return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_data | output | DW | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_pop | input | 1 | Shifter takes the oldest transmit byte |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_data | input | DW | Received byte |
| rx_perr | input | 1 | Parity error with this byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_brk | input | 1 | Break detected with this byte |
| modem_in | input | 4 | Modem input lines |
| line_ctrl | output | 8 | Line control setting |
| tx_break | output | 1 | Hold transmit line in break |
| modem_ctrl | output | 5 | Modem control setting |
| baud_div | output | 24 | Baud divisor {high, low} |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH=4 and DW=8. A four-entry queue fills within a few random writes or pushes, so a short run reaches the dropped write at full, the overrun on push at full, and the flush that coincides with a push. The same run reaches a status bit that latches again right after a clearing read. A reference model in the bench predicts every read value, the interrupt line, the transmit head and all the configuration outputs on every cycle.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [5:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_pop,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic [3:0]    modem_in,
  output logic [7:0]    line_ctrl,
  output logic          tx_break,
  output logic [4:0]    modem_ctrl,
  output logic [23:0]   baud_div,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_rp, tx_wp, rx_rp, rx_wp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [3:0]    err_q, en_q;
  logic [1:0]    st_q;
  logic [7:0]    lcr_q, divh_q;
  logic [4:0]    mcr_q;
  logic [15:0]   divl_q;

  logic [3:0] idx;
  logic rd, wr, tx_full, tx_nf, tx_empty, rx_ne, rx_full;
  logic tx_push, tx_take, rx_take, rx_flush, rx_put;
  logic unused_bits;

  assign idx      = bus_addr[5:2];
  assign rd       = bus_sel & ~bus_wr;
  assign wr       = bus_sel & bus_wr;
  assign tx_full  = (tx_cnt == FULL);
  assign tx_nf    = ~tx_full;
  assign tx_empty = (tx_cnt == '0);
  assign rx_ne    = (rx_cnt != '0);
  assign rx_full  = (rx_cnt == FULL);
  assign tx_push  = wr && idx == 4'd0 && !tx_full;
  assign tx_take  = tx_pop && !tx_empty;
  assign rx_take  = rd && idx == 4'd0 && rx_ne;
  assign rx_flush = wr && idx == 4'd9;
  assign rx_put   = rx_push && !rx_full && !rx_flush;
  assign unused_bits = &{1'b0, bus_addr[1:0], bus_wdata[31:16]};

  assign tx_data    = tx_mem[tx_rp];
  assign tx_valid   = !tx_empty;
  assign line_ctrl  = lcr_q;
  assign tx_break   = lcr_q[5];
  assign modem_ctrl = mcr_q;
  assign baud_div   = {divh_q, divl_q};
  assign irq        = (st_q[1] & en_q[1]) | (st_q[0] & en_q[0]);

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_put)  rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_take) tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_take);
      if (rx_flush) begin
        rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_put)  rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
        if (rx_take) rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(rx_put) - CW'(rx_take);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= '0; en_q <= '0; st_q <= '0;
      lcr_q <= '0; mcr_q <= '0; divl_q <= '0; divh_q <= '0;
    end else begin
      err_q <= ((rd && idx == 4'd1) ? 4'b0 : err_q)
             | {rx_push & rx_brk, rx_push & rx_ferr, rx_push & rx_full, rx_push & rx_perr};
      st_q  <= (rd && idx == 4'd7) ? 2'b0 : (st_q | {rx_ne, tx_nf});
      if (wr) begin
        case (idx)
          4'd3: lcr_q  <= bus_wdata[7:0];
          4'd4: mcr_q  <= bus_wdata[4:0];
          4'd5: divl_q <= bus_wdata[15:0];
          4'd6: divh_q <= bus_wdata[7:0];
          4'd7: en_q   <= bus_wdata[7:4];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      4'd0:    bus_rdata = rx_ne ? 32'(rx_mem[rx_rp]) : 32'd0;
      4'd1:    bus_rdata = {25'd0, tx_empty, err_q, rx_ne, tx_nf};
      4'd2:    bus_rdata = {28'd0, modem_in};
      4'd3:    bus_rdata = {24'd0, lcr_q};
      4'd4:    bus_rdata = {27'd0, mcr_q};
      4'd5:    bus_rdata = {16'd0, divl_q};
      4'd6:    bus_rdata = {24'd0, divh_q};
      4'd7:    bus_rdata = {24'd0, en_q, 2'b00, st_q};
      4'd8:    bus_rdata = 32'(tx_cnt);
      4'd9:    bus_rdata = 32'(rx_cnt);
      default: bus_rdata = 32'd0;
    endcase
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL && rx_cnt <= FULL); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) (wr && idx == 4'd0 && tx_full && !tx_pop) |=> $stable(tx_cnt)); // R2
  AST_PE_SET: assert property (@(posedge clk) disable iff (!rst_n) (rx_push && rx_perr) |=> bus_rdata[2] || idx != 4'd1); // R5
  AST_ISC_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n) (rd && idx == 4'd7) |=> !irq); // R6
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (wr && idx == 4'd7) |=> en_q == $past(bus_wdata[7:4])); // R7
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) rx_flush |=> rx_cnt == '0); // R9
endmodule

// File: tb/uart_regfile_bench.sv
module uart_regfile_bench;
  localparam int D = 4;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [5:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [7:0] tx_data, rx_data = 0;
  logic tx_valid, tx_pop = 0, rx_push = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
  logic [3:0] modem_in = 0;
  logic [7:0] line_ctrl;
  logic tx_break, irq;
  logic [4:0] modem_ctrl;
  logic [23:0] baud_div;

  uart_regfile #(.DEPTH(D), .DW(8)) u_uart_regfile (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .modem_in(modem_in), .line_ctrl(line_ctrl),
    .tx_break(tx_break), .modem_ctrl(modem_ctrl), .baud_div(baud_div), .irq(irq));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] txq[$], rxq[$];
  logic [3:0] m_err = 0, m_en = 0;
  logic [1:0] m_st = 0;
  logic [7:0] m_lcr = 0, m_divh = 0;
  logic [4:0] m_mcr = 0;
  logic [15:0] m_divl = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [3:0] i);
    case (i)
      0: return rxq.size() > 0 ? 32'(rxq[0]) : 32'd0;
      1: return {25'd0, txq.size() == 0, m_err, rxq.size() > 0, txq.size() < D};
      2: return {28'd0, modem_in};
      3: return {24'd0, m_lcr};
      4: return {27'd0, m_mcr};
      5: return {16'd0, m_divl};
      6: return {24'd0, m_divh};
      7: return {24'd0, m_en, 2'b00, m_st};
      8: return 32'(txq.size());
      9: return 32'(rxq.size());
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(logic [3:0] i);
    case (i)
      0: return "R3";
      1: return "R5";
      7: return "R6";
      8, 9: return "R9";
      2, 3, 4, 5, 6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic step(bit sel, bit wr, logic [5:0] a, logic [31:0] wd, bit pop,
                      bit push, logic [7:0] pd, bit pe, bit fe, bit bk, string tag);
    logic [3:0] i;
    int txs, rxs;
    bit rd, w;
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    tx_pop = pop; rx_push = push; rx_data = pd; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
    #2;
    i = a[5:2]; rd = sel && !wr; w = sel && wr;
    txs = txq.size(); rxs = rxq.size();
    if (rd) check(tag == "" ? read_tag(i) : tag, bus_rdata, exp_read(i));
    check("R8", 32'(irq), 32'((m_st[1] & m_en[1]) | (m_st[0] & m_en[0])));
    check("R2", 32'(tx_valid), 32'(txs > 0));
    if (txs > 0) check("R2", 32'(tx_data), 32'(txq[0]));
    check("R10", {line_ctrl, 3'b0, modem_ctrl, 15'b0, tx_break},
          {m_lcr, 3'b0, m_mcr, 15'b0, m_lcr[5]});
    check("R10", 32'(baud_div), {8'd0, m_divh, m_divl});
    @(posedge clk);
    if (pop && txs > 0) void'(txq.pop_front());
    if (w && i == 0 && txs < D) txq.push_back(wd[7:0]);
    m_err = ((rd && i == 1) ? 4'b0 : m_err) | {push & bk, push & fe, push & (rxs == D), push & pe};
    if (w && i == 9) rxq.delete();
    else begin
      if (rd && i == 0 && rxs > 0) void'(rxq.pop_front());
      if (push && rxs < D) rxq.push_back(pd);
    end
    m_st = (rd && i == 7) ? 2'b0 : (m_st | {rxs > 0, txs < D});
    if (w) case (i)
      3: m_lcr = wd[7:0];
      4: m_mcr = wd[4:0];
      5: m_divl = wd[15:0];
      6: m_divh = wd[7:0];
      7: m_en = wd[7:4];
      default: ;
    endcase
    @(negedge clk);
  endtask

  task automatic rd_reg(logic [3:0] i, string tag);
    step(1, 0, {i, 2'b00}, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wr_reg(logic [3:0] i, logic [31:0] v);
    step(1, 1, {i, 2'b00}, v, 0, 0, 0, 0, 0, 0, "");
  endtask
  task automatic rx_in(logic [7:0] v, bit pe, bit fe, bit bk);
    step(0, 0, 0, 0, 0, 1, v, pe, fe, bk, "");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values, read before any status latches disturb them
    check("R1", 32'(irq), 0);
    check("R1", bus_rdata, 32'd0);
    rd_reg(1, "R1");
    for (int k = 2; k < 10; k++) rd_reg(4'(k), "R1");
    // R2: fill transmit queue past full
    for (int k = 0; k < D + 2; k++) wr_reg(0, 32'hA0 + k);
    rd_reg(8, "R2");
    rd_reg(1, "R4");
    // R6/R7: enable tx interrupt, status survives an enable write
    wr_reg(7, 32'h0000_00FF);
    rd_reg(7, "R7");
    rd_reg(7, "R6");
    // R5: errors, overrun and sticky clear
    rx_in(8'h11, 1, 0, 0);
    rx_in(8'h22, 0, 1, 0);
    rx_in(8'h33, 0, 0, 1);
    rx_in(8'h44, 0, 0, 0);
    rx_in(8'h55, 0, 0, 0);
    rd_reg(1, "R5");
    rd_reg(1, "R5");
    rd_reg(0, "R3");
    // R9: flush together with a push
    step(1, 1, 6'h24, 0, 0, 1, 8'h66, 0, 0, 0, "");
    rd_reg(9, "R9");
    rd_reg(0, "R3");
    wr_reg(8, 32'h7);
    rd_reg(8, "R9");
    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 9);
      logic [3:0] i = 4'($urandom_range(0, 15));
      bit sel = (r < 6);
      bit wr = (r < 3);
      if (i > 9 && wr) i = 4'($urandom_range(0, 9));
      modem_in = 4'($urandom);
      step(sel, wr, {i, 2'b00}, $urandom, ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 2) == 0), 8'($urandom), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 9) == 0), "");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule